// File: doc/BRIEF.md
# Host-Triggered Sample Burst Dumper

The block sits between a stream of 24-bit signed audio samples and a byte-wide serial transmitter. It stays silent until the host sends the ASCII character '0' (0x30). It then captures a fixed-length burst of samples into an internal buffer. When the buffer is full it sends every sample as four bytes, stalling on the transmitter's ready signal for each byte.

An indicator output is held high while the burst is being sent. Capturing the whole burst before sending anything means the slow serial link never throttles the sampling rate. The burst length is the parameter `BURST_LEN`. Deployments set it to 8192 sample points. The default is kept smaller so the buffer stays compact when the block is elaborated on its own.

Top module: `sample_burst_dumper`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the block is in its idle state with `smp_ready_o`, `tx_valid_o` and `led_o` all low.
- R2: In the idle state only a received byte equal to 0x30 with `rx_valid_i` high starts a burst. Any other byte, or 0x30 without `rx_valid_i`, leaves all outputs unchanged.
- R3: From the cycle after the start command, `smp_ready_o` is high until exactly `BURST_LEN` samples have been accepted (`smp_valid_i` and `smp_ready_o` both high at a clock edge). It then drops.
- R4: While a burst is being captured or sent, received bytes, including 0x30, have no effect, and `smp_ready_o` stays low during sending.
- R5: Each sample is sign-extended from 24 to 32 bits and sent as four bytes, least significant byte first. Samples go out in the order they were captured.
- R6: Once `tx_valid_o` is high, it and `tx_byte_o` hold unchanged until `tx_ready_i` is high at a clock edge. The next byte appears only after that acceptance.
- R7: Exactly one cycle with `tx_valid_o` low precedes the first byte of every sample, both after capture ends and after the previous sample's fourth byte is accepted.
- R8: `led_o` rises in the cycle after the last sample is captured and stays high until the final byte is accepted. The block then returns to idle with `led_o` low and accepts a new start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_data_i | input | 24 | Signed audio sample |
| smp_valid_i | input | 1 | Sample available |
| smp_ready_o | output | 1 | Sample accepted when high with valid |
| rx_byte_i | input | 8 | Byte received from host |
| rx_valid_i | input | 1 | Received byte strobe |
| tx_byte_o | output | 8 | Byte to transmitter |
| tx_valid_o | output | 1 | Transmit byte presented |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| led_o | output | 1 | Sending indicator |

## Verification
The bench builds the block with `BURST_LEN` set to 6. This lets dozens of complete bursts run back to back, so every write and read index reaches its last value and wraps many times. Random stalls on sample valid and transmit ready, together with stray and repeated commands, land in every phase of a burst. Sign extremes 0x800000 and 0x7FFFFF appear often, and a reset mid-run checks recovery from a partial burst.

// File: rtl/burst_dump_pkg.sv
package burst_dump_pkg;
  localparam int unsigned SMP_BYTES = 4;
  localparam int unsigned WORD_W    = 8 * SMP_BYTES;
  localparam logic [7:0]  START_CMD = 8'h30;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_LOAD = 2'd2,
    ST_XMIT = 2'd3
  } dump_state_e;
endpackage

// File: rtl/burst_buffer.sv
module burst_buffer #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // sync write and registered read, no reset: maps onto block RAM
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/burst_byte_sel.sv
module burst_byte_sel
  import burst_dump_pkg::*;
#(
  parameter int unsigned IN_W = 24
) (
  input  logic [IN_W-1:0] sample_i,
  input  logic [1:0]      sel_i,
  output logic [7:0]      byte_o
);
  logic [WORD_W-1:0] word;

  assign word   = {{(WORD_W-IN_W){sample_i[IN_W-1]}}, sample_i};
  assign byte_o = word[8*sel_i +: 8];
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_dump_pkg::*;
#(
  parameter int unsigned BURST_LEN = 2048,
  localparam int unsigned AW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          rx_valid_i,
  input  logic          tx_ready_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [1:0]    byte_sel_o,
  output logic          smp_ready_o,
  output logic          tx_valid_o,
  output logic          led_o
);
  localparam logic [AW-1:0] LAST_IDX  = AW'(BURST_LEN - 1);
  localparam logic [1:0]    LAST_BYTE = 2'(SMP_BYTES - 1);

  dump_state_e   st_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [1:0]    sel_q;
  logic          cmd_hit;

  assign cmd_hit     = rx_valid_i && (rx_byte_i == START_CMD);
  assign smp_ready_o = (st_q == ST_CAPT);
  assign wr_en_o     = smp_ready_o && smp_valid_i;
  assign rd_en_o     = (st_q == ST_LOAD);
  assign tx_valid_o  = (st_q == ST_XMIT);
  assign led_o       = (st_q == ST_LOAD) || (st_q == ST_XMIT);
  assign wr_addr_o   = wr_q;
  assign rd_addr_o   = rd_q;
  assign byte_sel_o  = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      wr_q  <= '0;
      rd_q  <= '0;
      sel_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_hit) begin
          st_q <= ST_CAPT;
          wr_q <= '0;
        end
        ST_CAPT: if (smp_valid_i) begin
          if (wr_q == LAST_IDX) begin
            st_q <= ST_LOAD;
            rd_q <= '0;
          end else begin
            wr_q <= wr_q + 1'b1;
          end
        end
        ST_LOAD: begin
          st_q  <= ST_XMIT;
          sel_q <= '0;
        end
        ST_XMIT: if (tx_ready_i) begin
          if (sel_q == LAST_BYTE) begin
            if (rd_q == LAST_IDX) begin
              st_q <= ST_IDLE;
            end else begin
              rd_q <= rd_q + 1'b1;
              st_q <= ST_LOAD;
            end
          end else begin
            sel_q <= sel_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a non-command byte in idle does not open capture
  a_r2_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !cmd_hit) |=> !smp_ready_o);
  // R4: no sample handshake while sending
  a_r4_no_ready_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o |-> !smp_ready_o);
  // R6: presented byte holds until taken
  a_r6_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(byte_sel_o) && $stable(rd_addr_o)));
  // R7: one idle transmit cycle as the indicator rises
  a_r7_gap_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_o) |-> !tx_valid_o);
  // R8: indicator covers every transmitted byte
  a_r8_led_covers_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> led_o);
endmodule

// File: rtl/sample_burst_dumper.sv
module sample_burst_dumper #(
  parameter int unsigned BURST_LEN = 2048,
  parameter int unsigned SMP_W     = 24,
  localparam int unsigned AW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_valid_i,
  output logic [7:0]       tx_byte_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic             led_o
);
  logic             wr_en, rd_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [1:0]       byte_sel;
  logic [SMP_W-1:0] rd_data;

  burst_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .rx_byte_i   (rx_byte_i),
    .rx_valid_i  (rx_valid_i),
    .tx_ready_i  (tx_ready_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .byte_sel_o  (byte_sel),
    .smp_ready_o (smp_ready_o),
    .tx_valid_o  (tx_valid_o),
    .led_o       (led_o)
  );

  burst_buffer #(.DEPTH(BURST_LEN), .DATA_W(SMP_W)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (smp_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  burst_byte_sel #(.IN_W(SMP_W)) u_sel (
    .sample_i (rd_data),
    .sel_i    (byte_sel),
    .byte_o   (tx_byte_o)
  );

  // R1: reset leaves every handshake output low
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!smp_ready_o && !tx_valid_o && !led_o));
  // R3: capture and send never overlap
  a_r3_capture_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> !tx_valid_o);
endmodule

// File: tb/sim_sample_burst_dumper.sv
module sim_sample_burst_dumper;
  localparam int CLK_PERIOD = 10;
  localparam int LEN        = 6;
  localparam int N_CYC      = 1600;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] smp_data_i = '0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  tx_byte_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic        led_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference model state: 0 idle, 1 capture, 2 gap, 3 send
  int         ph = 0;
  int         cap_n = 0;
  int         sent_n = 0;
  bit         in_rst = 1'b1;
  logic [7:0] q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sample_burst_dumper #(.BURST_LEN(LEN)) u0 (
    .clk_i, .rst_ni, .smp_data_i, .smp_valid_i, .smp_ready_o,
    .rx_byte_i, .rx_valid_i, .tx_byte_o, .tx_valid_o, .tx_ready_i, .led_o
  );

  task automatic model_step();
    logic [31:0] w;
    in_rst = !rst_ni;
    if (!rst_ni) begin
      ph = 0; q.delete(); cap_n = 0; sent_n = 0;
      return;
    end
    case (ph)
      0: if (rx_valid_i && rx_byte_i == 8'h30) begin ph = 1; cap_n = 0; end
      1: if (smp_valid_i) begin
        w = 32'($signed(smp_data_i));  // R5 sign extension
        for (int b = 0; b < 4; b++) q.push_back(w[8*b +: 8]);  // R5 LSB first
        cap_n++;
        if (cap_n == LEN) begin ph = 2; sent_n = 0; end
      end
      2: ph = 3;
      3: if (tx_ready_i) begin
        void'(q.pop_front());
        sent_n++;
        if (sent_n % 4 == 0) ph = (q.size() == 0) ? 0 : 2;
      end
      default: ph = 0;
    endcase
  endtask

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t_rdy;
    vectors++;
    t_rdy = in_rst ? "R1 smp_ready" : (ph == 0 ? "R2 smp_ready" : "R3 R4 smp_ready");
    cmp(t_rdy, {7'b0, smp_ready_o}, {7'b0, ph == 1});
    cmp(in_rst ? "R1 tx_valid" : "R6 R7 tx_valid", {7'b0, tx_valid_o}, {7'b0, ph == 3});
    cmp(in_rst ? "R1 led" : "R8 led", {7'b0, led_o}, {7'b0, ph >= 2});
    if (ph == 3 && q.size() != 0) cmp("R5 R6 tx_byte", tx_byte_o, q[0]);
  endtask

  task automatic drive(int cyc);
    logic [31:0] r;
    rst_ni = !(cyc < 3 || cyc == 700 || cyc == 701);  // R1 mid-run reset
    r = $urandom;
    rx_valid_i = (r[1:0] == 2'd0);
    case (r[4:2])  // R2 R4 stray and repeated commands
      3'd0, 3'd1, 3'd2: rx_byte_i = 8'h30;
      3'd3: rx_byte_i = 8'h31;
      3'd4: rx_byte_i = 8'h2F;
      3'd5: rx_byte_i = 8'hB0;
      default: rx_byte_i = r[15:8];
    endcase
    r = $urandom;
    smp_valid_i = (r[1:0] != 2'd0);
    case (r[3:2])
      2'd0: smp_data_i = 24'h800000;
      2'd1: smp_data_i = 24'h7FFFFF;
      default: smp_data_i = r[31:8];
    endcase
    r = $urandom;
    tx_ready_i = (cyc >= 1200) ? 1'b1 : (r[2:0] > 3'd2);
  endtask

  initial begin
    for (int cyc = 0; cyc < N_CYC; cyc++) begin
      @(posedge clk_i);
      model_step();
      @(negedge clk_i);
      compare();
      drive(cyc);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule